// File: doc/BRIEF.md
# Reconfiguration Bridge Sequencer

This block controls one reconfiguration request for a programmable region. When the host issues a start command, the block asks a chosen set of bus bridges to freeze and waits until every one of them reports frozen. It then pulses a start strobe to the configuration engine and waits for that engine to report done or error. Only after a clean finish does it release the bridges, and it then waits for them to report running again. Each of the three waits has its own limit, counted in ticks of a one-microsecond strobe. If any phase fails, the bridges are left frozen and a distinct error code is reported.

The host selects between two modes. In full mode every bridge the block drives is gated. In partial mode only the bridge that belongs to the targeted region is gated, and all others keep carrying traffic. A separate teardown command freezes the selected bridges again when the region is taken out of service. The status code stays at its last result until the next accepted start. A start that arrives while a request is running is dropped and raises a sticky overrun flag.

Top module: `recfg_bridge_seq`

## Requirements
- R1: After reset, statusCode is 0 (idle), freezeReq is all zeros, cfgStart is low and overrun is low.
- R2: cfgStart is a single-cycle pulse that is issued only after every bridge requested to freeze reports frozen (frozenAck bit high). The freeze requests of the selected bridges are dropped only after cfgDone.
- R3: With cmdPartial low (full mode), an accepted start sets all NUM_BR bits of freezeReq, visible one cycle after the start edge, and statusCode becomes 1 (busy) at the same time.
- R4: With cmdPartial high (partial mode), an accepted start sets only bit cmdTarget of freezeReq. The other bits stay low.
- R5: When the engine reports done and the selected bridges then report released, statusCode becomes 2 (done) and the selected freezeReq bits are low.
- R6: If cfgError is seen while programming (error wins over a simultaneous done), statusCode becomes 4 and the selected bridges stay frozen. Every error code (3 to 6) is seen only with at least one freezeReq bit high.
- R7: If the selected bridges do not all report frozen within freezeLimitUs ticks, statusCode becomes 3 and the freeze requests stay high.
- R8: If the engine reports neither done nor error within cfgLimitUs ticks, statusCode becomes 6 and the bridges stay frozen.
- R9: If the bridges do not all report released within unfreezeLimitUs ticks, statusCode becomes 5 and the selected freezeReq bits are set again.
- R10: A limit of zero removes the time limit for that phase, and the block waits without end.
- R11: A result code (anything other than 1) keeps its value until the next accepted start.
- R12: A start while busy is ignored: the selected bridge set is unchanged, and overrun goes high and stays high until reset.
- R13: A teardown command while not busy sets the freezeReq bits chosen by cmdPartial and cmdTarget one cycle later and leaves statusCode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | Start a reconfiguration request (one-cycle pulse) |
| cmdTeardown | input | 1 | Freeze the selected bridges again (one-cycle pulse) |
| cmdPartial | input | 1 | 1 = partial mode, 0 = full mode |
| cmdTarget | input | IDX_W | Index of the region bridge used in partial mode |
| freezeLimitUs | input | TO_W | Freeze-phase limit in microseconds, 0 = no limit |
| cfgLimitUs | input | TO_W | Programming-phase limit in microseconds, 0 = no limit |
| unfreezeLimitUs | input | TO_W | Release-phase limit in microseconds, 0 = no limit |
| usTick | input | 1 | One-cycle strobe every microsecond |
| frozenAck | input | NUM_BR | Per-bridge report, 1 = frozen |
| freezeReq | output | NUM_BR | Per-bridge freeze request |
| cfgStart | output | 1 | Start pulse to the configuration engine |
| cfgDone | input | 1 | Engine reports the device is operating |
| cfgError | input | 1 | Engine reports programming failed |
| statusCode | output | 3 | 0 idle, 1 busy, 2 done, 3 freeze timeout, 4 program error, 5 release timeout, 6 config timeout |
| overrun | output | 1 | Sticky flag: a start arrived while busy |

## Verification
Busy status and the freeze request mask appear one clock after the start edge, and teardown freezes bridges one clock after its edge. The bench samples both on the falling edge that follows. A final result code appears one clock after the deciding event, which is the last acknowledge, the engine's report or the limit being reached. The monitor catches it on the falling edge where statusCode first leaves busy and compares it against the item queued when that start was driven, so no check depends on a fixed total latency. Limit expiry is checked by result rather than by cycle, because its exact cycle depends on the tick phase.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_BUSY         = 3'd1,
    ST_DONE         = 3'd2,
    ST_ERR_FREEZE   = 3'd3,
    ST_ERR_PROG     = 3'd4,
    ST_ERR_UNFREEZE = 3'd5,
    ST_ERR_CFG      = 3'd6
  } seqStatus_e;

  typedef enum logic [1:0] {
    LIM_FREEZE   = 2'd0,
    LIM_CFG      = 2'd1,
    LIM_UNFREEZE = 2'd2
  } limSel_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       loadMask;     // latch bridge selection, request freeze
    logic       releaseMask;  // drop freeze requests of latched selection
    logic       refreezeMask; // raise freeze requests of latched selection again
    logic       teardown;     // freeze the currently selected bridges
    logic       clrCnt;       // restart the microsecond counter
    logic       setStatus;
    seqStatus_e statusVal;
    limSel_e    limSel;
    logic       overrun;
  } ctlStrobe_t;

endpackage

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdTeardown,
  input  logic       cfgDone,
  input  logic       cfgError,
  input  logic       allFrozen,
  input  logic       allReleased,
  input  logic       timedOut,
  output ctlStrobe_t strb,
  output logic       cfgStart
);

  typedef enum logic [2:0] {
    S_IDLE, S_FREEZE, S_PSTART, S_PWAIT, S_UNFREEZE
  } seqState_e;

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign cfgStart = (state == S_PSTART);

  always_comb begin
    strb           = '0;
    strb.statusVal = ST_IDLE;
    strb.limSel    = LIM_FREEZE;
    stateNxt       = state;
    strb.overrun   = cmdStart && (state != S_IDLE);
    unique case (state)
      S_IDLE: begin
        if (cmdStart) begin
          strb.loadMask  = 1'b1;
          strb.clrCnt    = 1'b1;
          strb.setStatus = 1'b1;
          strb.statusVal = ST_BUSY;
          stateNxt       = S_FREEZE;
        end else if (cmdTeardown) begin
          strb.teardown = 1'b1;
        end
      end
      S_FREEZE: begin
        strb.limSel = LIM_FREEZE;
        if (allFrozen) begin
          stateNxt = S_PSTART;
        end else if (timedOut) begin
          strb.setStatus = 1'b1;
          strb.statusVal = ST_ERR_FREEZE;
          stateNxt       = S_IDLE;
        end
      end
      S_PSTART: begin
        strb.limSel = LIM_CFG;
        strb.clrCnt = 1'b1;
        stateNxt    = S_PWAIT;
      end
      S_PWAIT: begin
        strb.limSel = LIM_CFG;
        if (cfgError) begin
          strb.setStatus = 1'b1;
          strb.statusVal = ST_ERR_PROG;
          stateNxt       = S_IDLE;
        end else if (cfgDone) begin
          strb.releaseMask = 1'b1;
          strb.clrCnt      = 1'b1;
          stateNxt         = S_UNFREEZE;
        end else if (timedOut) begin
          strb.setStatus = 1'b1;
          strb.statusVal = ST_ERR_CFG;
          stateNxt       = S_IDLE;
        end
      end
      S_UNFREEZE: begin
        strb.limSel = LIM_UNFREEZE;
        if (allReleased) begin
          strb.setStatus = 1'b1;
          strb.statusVal = ST_DONE;
          stateNxt       = S_IDLE;
        end else if (timedOut) begin
          strb.refreezeMask = 1'b1;
          strb.setStatus    = 1'b1;
          strb.statusVal    = ST_ERR_UNFREEZE;
          stateNxt          = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/rbs_datapath.sv
module rbs_datapath
  import rbs_pkg::*;
#(
  parameter int NUM_BR = 4,
  parameter int TO_W   = 16,
  localparam int IDX_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              cmdPartial,
  input  logic [IDX_W-1:0]  cmdTarget,
  input  logic [TO_W-1:0]   freezeLimitUs,
  input  logic [TO_W-1:0]   cfgLimitUs,
  input  logic [TO_W-1:0]   unfreezeLimitUs,
  input  logic              usTick,
  input  logic [NUM_BR-1:0] frozenAck,
  output logic [NUM_BR-1:0] freezeReq,
  output logic [2:0]        statusCode,
  output logic              overrun,
  output logic              allFrozen,
  output logic              allReleased,
  output logic              timedOut
);

  logic [NUM_BR-1:0] selMask;
  logic [NUM_BR-1:0] activeMask;
  logic [TO_W-1:0]   usCnt;
  logic [TO_W-1:0]   curLimit;
  seqStatus_e        statusReg;

  // bridge selection: full mode takes every bridge, partial only the target
  for (genvar gi = 0; gi < NUM_BR; gi++) begin : g_sel
    assign selMask[gi] = !cmdPartial || (cmdTarget == IDX_W'(gi));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMask <= '0;
      freezeReq  <= '0;
    end else begin
      if (strb.loadMask) activeMask <= selMask;
      if (strb.loadMask || strb.teardown) freezeReq <= freezeReq | selMask;
      else if (strb.releaseMask)          freezeReq <= freezeReq & ~activeMask;
      else if (strb.refreezeMask)         freezeReq <= freezeReq | activeMask;
    end
  end

  assign allFrozen   = ((frozenAck & activeMask) == activeMask);
  assign allReleased = ((frozenAck & activeMask) == '0);

  // microsecond counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    usCnt <= '0;
    else if (strb.clrCnt)         usCnt <= '0;
    else if (usTick && usCnt != '1) usCnt <= usCnt + 1'b1;
  end

  always_comb begin
    unique case (strb.limSel)
      LIM_CFG:      curLimit = cfgLimitUs;
      LIM_UNFREEZE: curLimit = unfreezeLimitUs;
      default:      curLimit = freezeLimitUs;
    endcase
  end

  assign timedOut = (curLimit != '0) && (usCnt >= curLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= ST_IDLE;
      overrun   <= 1'b0;
    end else begin
      if (strb.setStatus) statusReg <= strb.statusVal;
      if (strb.overrun)   overrun   <= 1'b1;
    end
  end

  assign statusCode = statusReg;

endmodule

// File: rtl/recfg_bridge_seq.sv
module recfg_bridge_seq
  import rbs_pkg::*;
#(
  parameter int NUM_BR = 4,
  parameter int TO_W   = 16,
  localparam int IDX_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdTeardown,
  input  logic              cmdPartial,
  input  logic [IDX_W-1:0]  cmdTarget,
  input  logic [TO_W-1:0]   freezeLimitUs,
  input  logic [TO_W-1:0]   cfgLimitUs,
  input  logic [TO_W-1:0]   unfreezeLimitUs,
  input  logic              usTick,
  input  logic [NUM_BR-1:0] frozenAck,
  output logic [NUM_BR-1:0] freezeReq,
  output logic              cfgStart,
  input  logic              cfgDone,
  input  logic              cfgError,
  output logic [2:0]        statusCode,
  output logic              overrun
);

  ctlStrobe_t strb;
  logic       allFrozen;
  logic       allReleased;
  logic       timedOut;

  rbs_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdStart    (cmdStart),
    .cmdTeardown (cmdTeardown),
    .cfgDone     (cfgDone),
    .cfgError    (cfgError),
    .allFrozen   (allFrozen),
    .allReleased (allReleased),
    .timedOut    (timedOut),
    .strb        (strb),
    .cfgStart    (cfgStart)
  );

  rbs_datapath #(.NUM_BR(NUM_BR), .TO_W(TO_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .cmdPartial      (cmdPartial),
    .cmdTarget       (cmdTarget),
    .freezeLimitUs   (freezeLimitUs),
    .cfgLimitUs      (cfgLimitUs),
    .unfreezeLimitUs (unfreezeLimitUs),
    .usTick          (usTick),
    .frozenAck       (frozenAck),
    .freezeReq       (freezeReq),
    .statusCode      (statusCode),
    .overrun         (overrun),
    .allFrozen       (allFrozen),
    .allReleased     (allReleased),
    .timedOut        (timedOut)
  );

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int NUM_BR = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic [NUM_BR-1:0] frozenAck,
  input logic [NUM_BR-1:0] freezeReq,
  input logic              cfgStart,
  input logic [2:0]        statusCode,
  input logic              overrun
);

  // R2: engine started only when every requested bridge reports frozen
  p_start_after_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |-> (freezeReq != '0) && ((frozenAck & freezeReq) == freezeReq));

  // R2: start strobe lasts one cycle
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |=> !cfgStart);

  // R2: start strobe only while busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |-> (statusCode == 3'd1));

  // R6: every error result leaves bridges frozen
  p_err_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode >= 3'd3) |-> (freezeReq != '0));

  // R11: result held until the next start
  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statusCode != 3'd1 && !cmdStart) |=> $stable(statusCode));

  // R12: overrun is sticky
  p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind recfg_bridge_seq rbs_checker #(.NUM_BR(NUM_BR)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdStart   (cmdStart),
  .frozenAck  (frozenAck),
  .freezeReq  (freezeReq),
  .cfgStart   (cfgStart),
  .statusCode (statusCode),
  .overrun    (overrun)
);

// File: tb/recfg_bridge_seq_tb.sv
`timescale 1ns/1ps
module recfg_bridge_seq_tb;

  localparam int NUM_BR = 4;
  localparam int TO_W   = 16;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdTeardown = 1'b0, cmdPartial = 1'b0;
  logic [IDX_W-1:0] cmdTarget = '0;
  logic [TO_W-1:0] freezeLimitUs = 16'd5, cfgLimitUs = 16'd8, unfreezeLimitUs = 16'd5;
  logic usTick;
  logic [NUM_BR-1:0] frozenAck, freezeReq;
  logic cfgStart, cfgDone, cfgError, overrun;
  logic [2:0] statusCode;

  int ackMode = 0;   // 0 follows requests, 1 never frozen, 2 always frozen
  int cfgMode = 0;   // 0 done, 1 error, 2 silent
  logic manualDone = 1'b0;

  int errors = 0, checks = 0, results = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  recfg_bridge_seq #(.NUM_BR(NUM_BR), .TO_W(TO_W)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdTeardown(cmdTeardown),
    .cmdPartial(cmdPartial), .cmdTarget(cmdTarget), .freezeLimitUs(freezeLimitUs),
    .cfgLimitUs(cfgLimitUs), .unfreezeLimitUs(unfreezeLimitUs), .usTick(usTick),
    .frozenAck(frozenAck), .freezeReq(freezeReq), .cfgStart(cfgStart),
    .cfgDone(cfgDone), .cfgError(cfgError), .statusCode(statusCode), .overrun(overrun));

  // microsecond tick every 4 cycles
  logic [1:0] tickDiv = '0;
  always @(posedge clk) tickDiv <= tickDiv + 2'd1;
  assign usTick = (tickDiv == 2'd3);

  // bridge model
  logic [NUM_BR-1:0] ackD1 = '0, ackD2 = '0;
  always @(posedge clk) begin ackD1 <= freezeReq; ackD2 <= ackD1; end
  assign frozenAck = (ackMode == 1) ? '0 : (ackMode == 2) ? '1 : ackD2;

  // configuration engine model: answers 3 cycles after the start pulse
  int cfgCnt = 0;
  logic fire = 1'b0;
  always @(posedge clk) begin
    fire <= 1'b0;
    if (cfgStart) cfgCnt <= 3;
    else if (cfgCnt > 0) begin
      cfgCnt <= cfgCnt - 1;
      if (cfgCnt == 1) fire <= 1'b1;
    end
  end
  assign cfgDone  = (fire && cfgMode == 0) || manualDone;
  assign cfgError = fire && cfgMode == 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [2:0] st; logic [NUM_BR-1:0] fr; string tag; } expItem_t;
  expItem_t expQ[$];

  // monitor: compares each result as it leaves busy
  logic [2:0] prevStatus = 3'd0;
  always @(negedge clk) begin
    if (rstN) begin
      if (cfgStart)
        chk((frozenAck & freezeReq) == freezeReq && freezeReq != 0,
            "R2 cfgStart before all frozen", frozenAck, freezeReq);
      if (prevStatus == 3'd1 && statusCode != 3'd1) begin
        if (expQ.size() == 0) chk(0, "unexpected result", statusCode, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(statusCode == e.st, {e.tag, " status"}, statusCode, e.st);
          chk(freezeReq == e.fr, {e.tag, " freezeReq"}, freezeReq, e.fr);
        end
        results++;
      end
    end
    prevStatus = statusCode;
  end

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(statusCode == 3'd0, "R1 status", statusCode, 0);
    chk(freezeReq == '0, "R1 freezeReq", freezeReq, 0);
    chk(cfgStart == 1'b0 && overrun == 1'b0, "R1 cfgStart/overrun", {cfgStart, overrun}, 0);
  endtask

  // driver: push expected result, pulse start, check busy mask
  task automatic startReq(input bit partial, input int tgt, input logic [NUM_BR-1:0] during,
                          input logic [2:0] expSt, input logic [NUM_BR-1:0] expFr,
                          input string tag);
    expItem_t e;
    e.st = expSt; e.fr = expFr; e.tag = tag;
    expQ.push_back(e);
    cmdPartial = partial; cmdTarget = IDX_W'(tgt); cmdStart = 1'b1;
    @(negedge clk); cmdStart = 1'b0;
    chk(statusCode == 3'd1, {tag, " busy"}, statusCode, 1);
    chk(freezeReq == during, {tag, " freeze mask"}, freezeReq, during);
  endtask

  task automatic waitResult(input int n);
    while (results < n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doReset();

    // R3 R5 full mode success
    startReq(0, 0, 4'hF, 3'd2, 4'h0, "R3 R5 full");
    waitResult(1);

    // R4 partial success
    startReq(1, 2, 4'b0100, 3'd2, 4'h0, "R4 partial");
    waitResult(2);

    // R12 start while busy
    startReq(1, 1, 4'b0010, 3'd2, 4'h0, "R12 first");
    cmdPartial = 1'b0; cmdStart = 1'b1;
    @(negedge clk); cmdStart = 1'b0;
    chk(overrun == 1'b1, "R12 overrun set", overrun, 1);
    chk(freezeReq == 4'b0010, "R12 mask unchanged", freezeReq, 4'b0010);
    waitResult(3);
    chk(overrun == 1'b1, "R12 overrun sticky", overrun, 1);
    doReset();

    // R7 freeze timeout
    ackMode = 1;
    startReq(0, 0, 4'hF, 3'd3, 4'hF, "R7 freeze timeout");
    waitResult(4);
    ackMode = 0;
    doReset();

    // R6 program error, R11 hold
    cfgMode = 1;
    startReq(1, 3, 4'b1000, 3'd4, 4'b1000, "R6 prog error");
    waitResult(5);
    repeat (30) @(negedge clk);
    chk(statusCode == 3'd4, "R11 status hold", statusCode, 4);
    doReset();

    // R8 config timeout
    cfgMode = 2;
    startReq(0, 0, 4'hF, 3'd6, 4'hF, "R8 cfg timeout");
    waitResult(6);
    doReset();

    // R9 release timeout
    cfgMode = 0; ackMode = 2;
    startReq(1, 0, 4'b0001, 3'd5, 4'b0001, "R9 unfreeze timeout");
    waitResult(7);
    ackMode = 0;
    doReset();

    // R10 zero limit waits without end
    cfgMode = 2; cfgLimitUs = '0;
    startReq(0, 0, 4'hF, 3'd2, 4'h0, "R10 no limit");
    repeat (300) @(negedge clk);
    chk(statusCode == 3'd1, "R10 still busy", statusCode, 1);
    manualDone = 1'b1;
    @(negedge clk); manualDone = 1'b0;
    waitResult(8);
    cfgLimitUs = 16'd8; cfgMode = 0;

    // R13 teardown
    cmdPartial = 1'b1; cmdTarget = 2'd1; cmdTeardown = 1'b1;
    @(negedge clk); cmdTeardown = 1'b0;
    chk(freezeReq == 4'b0010, "R13 teardown partial", freezeReq, 4'b0010);
    chk(statusCode == 3'd2, "R13 status unchanged", statusCode, 2);
    cmdPartial = 1'b0; cmdTeardown = 1'b1;
    @(negedge clk); cmdTeardown = 1'b0;
    chk(freezeReq == 4'hF, "R13 teardown full", freezeReq, 4'hF);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule